// File: doc/BRIEF.md
# Partitioned Victim Way Allocator

This block chooses where a new line goes in an eight-way set-associative cache shared by two processors and an external push-in (stash) source. Each way belongs to exactly one owner class, held in a table that software loads through a small write port. A write names a mask of ways and a class code. The block checks the write against the grouping rules and either applies it or rejects it and raises an error flag.

For each request the block reads the requester's source, whether the lookup hit, the hit way and the per-way valid bits of the addressed set. It then returns a registered decision. On a miss it allocates a victim way, or it declares the access non-allocating. On a hit it updates the hit way in place. Among a requester's eligible ways it takes the lowest-numbered invalid way. When all eligible ways are valid, a rotating pointer kept for each requester decides. A mode bit stops stash misses from allocating, so stash writes only refresh lines that are already resident.

Top module: `way_part_alloc`

## Requirements
- R1: After reset every way has class code 4 (shared), the stash no-allocate mode is off, all rotating pointers are 0, and dec_valid, dec_alloc, dec_update, dec_noalloc and cfg_err are 0.
- R2: Class codes are 0 SRAM, 1 stash-only, 2 CPU0-only, 3 CPU1-only and 4 shared. An accepted configuration write sets every way whose cfg_mask bit is 1 to cfg_cls. The change is seen by a request presented in the next cycle or later.
- R3: A configuration write is rejected if its mask holds a number of set bits other than 1, 2, 4 or 8, or if it uses a class code from 5 to 7. A rejected write leaves the table unchanged, and cfg_err is 1 in the cycle after it. cfg_err is 0 after any cycle without a rejected write.
- R4: A configuration write is also rejected, in the same way as under R3, if the resulting number of stash-only ways is not 0, 1, 2 or 4.
- R5: A stash miss (req_src 2) may allocate only stash-only ways. A processor miss never allocates a stash-only way.
- R6: A way of class SRAM is never chosen as a victim.
- R7: A CPU0 miss (req_src 0) may use CPU0-only and shared ways. A CPU1 miss (req_src 1) may use CPU1-only and shared ways. req_src 3 has no eligible ways.
- R8: On an allocating miss where some eligible way has its req_line_valid bit at 0, the victim is the lowest-numbered such way, and the pointers do not move.
- R9: On an allocating miss where all eligible ways are valid, the victim is the first eligible way at or after the requester's pointer, counting upward with wrap from 7 to 0. That pointer then becomes victim+1 mod 8.
- R10: A miss with no eligible ways gives dec_noalloc=1, dec_alloc=0 and dec_victim=0.
- R11: A hit gives dec_update=1, dec_victim=req_hit_way, dec_alloc=0 and dec_noalloc=0, and leaves the pointers unchanged.
- R12: With the stash no-allocate mode set, a stash miss gives dec_noalloc=1 and dec_victim=0, while a stash hit still updates as in R11.
- R13: Every decision output is registered. dec_valid equals req_valid one cycle earlier, and dec_alloc, dec_update and dec_noalloc are never more than one at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Class table write strobe |
| cfg_mask | input | 8 | Ways targeted by the write |
| cfg_cls | input | 3 | Class code written to the targeted ways |
| mode_we | input | 1 | Stash no-allocate mode write strobe |
| mode_stash_noalloc | input | 1 | New value of the stash no-allocate mode |
| req_valid | input | 1 | Request present |
| req_src | input | 2 | Requester: 0 CPU0, 1 CPU1, 2 stash, 3 none |
| req_hit | input | 1 | Lookup hit |
| req_hit_way | input | 3 | Way that hit |
| req_line_valid | input | 8 | Valid bits of the addressed set |
| dec_valid | output | 1 | Decision present |
| dec_alloc | output | 1 | Allocate into dec_victim |
| dec_victim | output | 3 | Chosen or hit way |
| dec_update | output | 1 | Update resident line in place |
| dec_noalloc | output | 1 | Access passes through without allocation |
| cfg_err | output | 1 | Previous configuration write was rejected |

## Verification
A corrupted class table entry shows up on the very next request from an affected requester, as a victim outside its partition or as a spurious no-allocate. The bench therefore sweeps every source against all 256 valid-bit patterns right after each configuration. A drifting rotating pointer stays hidden until a set is full, so the sweeps contain many all-valid requests in a row. There the wrong way appears within a single decision. Rejected writes are compared through cfg_err one cycle later, and through the victims of the following sweep, which would expose a table that was partly written.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

   typedef enum logic [2:0] {
      CLS_SRAM   = 3'd0,
      CLS_STASH  = 3'd1,
      CLS_CPU0   = 3'd2,
      CLS_CPU1   = 3'd3,
      CLS_SHARED = 3'd4
   } way_cls_e;

   typedef enum logic [1:0] {
      SRC_CPU0  = 2'd0,
      SRC_CPU1  = 2'd1,
      SRC_STASH = 2'd2,
      SRC_NONE  = 2'd3
   } req_src_e;

   localparam int CLS_W = 3;
   localparam int SRC_W = 2;

endpackage

// File: rtl/wpa_cfg_table.sv
module wpa_cfg_table
   import wpa_pkg::*;
#(
   parameter int NUM_WAYS  = 8,
   parameter int MAX_STASH = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [NUM_WAYS-1:0]             wr_mask,
   input  logic [CLS_W-1:0]                wr_cls,
   input  logic                            mode_we,
   input  logic                            mode_val,
   output logic [NUM_WAYS-1:0][CLS_W-1:0]  tbl_o,
   output logic                            mode_o,
   output logic                            err_o
);

   localparam int CNT_W = $clog2(NUM_WAYS + 1);

   logic [NUM_WAYS-1:0][CLS_W-1:0] tbl_q, tbl_nx;
   logic [NUM_WAYS-1:0]            stash_nx_v, stash_cur_v;
   logic [CNT_W-1:0]               wr_cnt, stash_nx_cnt, stash_cur_cnt;
   logic                           grp_ok, cls_ok, stash_ok, accept;
   logic                           mode_q, err_q;

   function automatic logic [CNT_W-1:0] popc(input logic [NUM_WAYS-1:0] v);
      logic [CNT_W-1:0] n;
      n = '0;
      for (int i = 0; i < NUM_WAYS; i++) n = n + CNT_W'(v[i]);
      return n;
   endfunction

   function automatic logic pow2_upto(input logic [CNT_W-1:0] c, input int lim);
      return (c != '0) && ((c & (c - CNT_W'(1))) == '0) && (int'(c) <= lim);
   endfunction

   always_comb begin
      tbl_nx = tbl_q;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (wr_mask[w]) tbl_nx[w] = wr_cls;
         stash_nx_v[w]  = (tbl_nx[w] == CLS_STASH);
         stash_cur_v[w] = (tbl_q[w]  == CLS_STASH);
      end
      wr_cnt        = popc(wr_mask);
      stash_nx_cnt  = popc(stash_nx_v);
      stash_cur_cnt = popc(stash_cur_v);
      grp_ok   = pow2_upto(wr_cnt, NUM_WAYS);
      cls_ok   = (wr_cls <= CLS_SHARED);
      stash_ok = (stash_nx_cnt == '0) || pow2_upto(stash_nx_cnt, MAX_STASH);
      accept   = grp_ok && cls_ok && stash_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WAYS; w++) tbl_q[w] <= CLS_SHARED;
         mode_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (wr_en && accept) tbl_q <= tbl_nx;
         if (mode_we) mode_q <= mode_val;
         err_q <= wr_en && !accept;
      end
   end

   assign tbl_o  = tbl_q;
   assign mode_o = mode_q;
   assign err_o  = err_q;

   // R4
   stash_count_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stash_cur_cnt == '0) || pow2_upto(stash_cur_cnt, MAX_STASH));

   // R3
   reject_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (tbl_q == $past(tbl_q)));

endmodule

// File: rtl/wpa_elig.sv
module wpa_elig
   import wpa_pkg::*;
#(
   parameter int NUM_WAYS = 8
) (
   input  logic [NUM_WAYS-1:0][CLS_W-1:0] tbl,
   input  logic [SRC_W-1:0]               src,
   output logic [NUM_WAYS-1:0]            elig
);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic is_stash, is_c0, is_c1, is_sh;
      assign is_stash = (tbl[w] == CLS_STASH);
      assign is_c0    = (tbl[w] == CLS_CPU0);
      assign is_c1    = (tbl[w] == CLS_CPU1);
      assign is_sh    = (tbl[w] == CLS_SHARED);
      always_comb begin
         unique case (src)
            SRC_CPU0:  elig[w] = is_c0 || is_sh;
            SRC_CPU1:  elig[w] = is_c1 || is_sh;
            SRC_STASH: elig[w] = is_stash;
            default:   elig[w] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/wpa_victim_sel.sv
module wpa_victim_sel
   import wpa_pkg::*;
#(
   parameter int NUM_WAYS = 8,
   parameter int NUM_SRC  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fire,
   input  logic [SRC_W-1:0]            src,
   input  logic [NUM_WAYS-1:0]         elig,
   input  logic [NUM_WAYS-1:0]         line_valid,
   output logic                        any_elig,
   output logic [$clog2(NUM_WAYS)-1:0] victim,
   output logic                        by_rr
);

   localparam int WW = $clog2(NUM_WAYS);

   logic [NUM_SRC-1:0][WW-1:0] ptr_q;
   logic [NUM_WAYS-1:0]        inv;
   logic [WW-1:0]              lo_way, rr_way, cur_ptr, idx;
   logic                       lo_hit, src_ok;

   always_comb begin
      inv      = elig & ~line_valid;
      any_elig = |elig;
      src_ok   = (int'(src) < NUM_SRC);
      cur_ptr  = src_ok ? ptr_q[src] : '0;
      lo_hit   = 1'b0;
      lo_way   = '0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         if (inv[i]) begin
            lo_hit = 1'b1;
            lo_way = WW'(i);
         end
      end
      rr_way = '0;
      idx    = '0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         idx = cur_ptr + WW'(i);
         if (elig[idx]) rr_way = idx;
      end
      victim = lo_hit ? lo_way : rr_way;
      by_rr  = !lo_hit && any_elig;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (fire && by_rr && src_ok) begin
         ptr_q[src] <= rr_way + WW'(1);
      end
   end

   // R9
   ptr_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && by_rr) |=> (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/way_part_alloc.sv
module way_part_alloc
   import wpa_pkg::*;
#(
   parameter int NUM_WAYS  = 8,
   parameter int MAX_STASH = 4,
   parameter int NUM_SRC   = 3,
   localparam int WW       = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [NUM_WAYS-1:0] cfg_mask,
   input  logic [2:0]          cfg_cls,
   input  logic                mode_we,
   input  logic                mode_stash_noalloc,
   input  logic                req_valid,
   input  logic [1:0]          req_src,
   input  logic                req_hit,
   input  logic [WW-1:0]       req_hit_way,
   input  logic [NUM_WAYS-1:0] req_line_valid,
   output logic                dec_valid,
   output logic                dec_alloc,
   output logic [WW-1:0]       dec_victim,
   output logic                dec_update,
   output logic                dec_noalloc,
   output logic                cfg_err
);

   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (MAX_STASH < 1 || MAX_STASH >= NUM_WAYS) begin : g_bad_stash
      $error("MAX_STASH must lie between 1 and NUM_WAYS-1");
   end
   if (NUM_SRC != 3) begin : g_bad_src
      $error("NUM_SRC must be 3 (two processors and one stash source)");
   end

   logic [NUM_WAYS-1:0][CLS_W-1:0] tbl;
   logic                           mode;
   logic [NUM_WAYS-1:0]            elig;
   logic                           any_elig, by_rr, stash_block, pick_fire;
   logic [WW-1:0]                  pick_way;

   logic                           v_q, al_q, up_q, na_q;
   logic [WW-1:0]                  vic_q;
   logic [NUM_WAYS-1:0]            elig_q, lv_q;

   wpa_cfg_table #(.NUM_WAYS(NUM_WAYS), .MAX_STASH(MAX_STASH)) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_mask(cfg_mask), .wr_cls(cfg_cls),
      .mode_we(mode_we), .mode_val(mode_stash_noalloc),
      .tbl_o(tbl), .mode_o(mode), .err_o(cfg_err)
   );

   wpa_elig #(.NUM_WAYS(NUM_WAYS)) elig_i (
      .tbl(tbl), .src(req_src), .elig(elig)
   );

   assign stash_block = (req_src == SRC_STASH) && mode;
   assign pick_fire   = req_valid && !req_hit && !stash_block;

   wpa_victim_sel #(.NUM_WAYS(NUM_WAYS), .NUM_SRC(NUM_SRC)) sel_i (
      .clk(clk), .rst_n(rst_n),
      .fire(pick_fire), .src(req_src), .elig(elig),
      .line_valid(req_line_valid),
      .any_elig(any_elig), .victim(pick_way), .by_rr(by_rr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         al_q   <= 1'b0;
         up_q   <= 1'b0;
         na_q   <= 1'b0;
         vic_q  <= '0;
         elig_q <= '0;
         lv_q   <= '0;
      end else begin
         v_q    <= req_valid;
         elig_q <= elig;
         lv_q   <= req_line_valid;
         al_q   <= 1'b0;
         up_q   <= 1'b0;
         na_q   <= 1'b0;
         vic_q  <= '0;
         if (req_valid) begin
            if (req_hit) begin
               up_q  <= 1'b1;
               vic_q <= req_hit_way;
            end else if (pick_fire && any_elig) begin
               al_q  <= 1'b1;
               vic_q <= pick_way;
            end else begin
               na_q <= 1'b1;
            end
         end
      end
   end

   assign dec_valid   = v_q;
   assign dec_alloc   = al_q;
   assign dec_update  = up_q;
   assign dec_noalloc = na_q;
   assign dec_victim  = vic_q;

   // R13
   dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid == $past(req_valid));

   // R13
   dec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec_alloc, dec_update, dec_noalloc}));

   // R6
   victim_in_partition_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_alloc |-> elig_q[dec_victim]);

   // R8
   lowest_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_alloc && |(elig_q & ~lv_q)) |-> !lv_q[dec_victim]);

   // R11
   hit_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit) |=> (dec_update && dec_victim == $past(req_hit_way)));

   // R12
   stash_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && stash_block) |=> (dec_noalloc && !dec_alloc));

endmodule

// File: tb/way_part_alloc_tb.sv
`timescale 1ns/1ps
module way_part_alloc_tb_top;

   localparam int NW = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_mask = '0;
   logic [2:0] cfg_cls = '0;
   logic       mode_we = 1'b0;
   logic       mode_stash_noalloc = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_src = '0;
   logic       req_hit = 1'b0;
   logic [2:0] req_hit_way = '0;
   logic [7:0] req_line_valid = '0;
   logic       dec_valid, dec_alloc, dec_update, dec_noalloc, cfg_err;
   logic [2:0] dec_victim;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_cls [NW];
   int m_ptr [3];
   bit m_mode;

   always #4 clk = ~clk;

   way_part_alloc dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_cls(cfg_cls),
      .mode_we(mode_we), .mode_stash_noalloc(mode_stash_noalloc),
      .req_valid(req_valid), .req_src(req_src), .req_hit(req_hit),
      .req_hit_way(req_hit_way), .req_line_valid(req_line_valid),
      .dec_valid(dec_valid), .dec_alloc(dec_alloc), .dec_victim(dec_victim),
      .dec_update(dec_update), .dec_noalloc(dec_noalloc), .cfg_err(cfg_err)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic bit m_elig(input int src, input int w);
      case (src)
         0: return m_cls[w] == 2 || m_cls[w] == 4;
         1: return m_cls[w] == 3 || m_cls[w] == 4;
         2: return m_cls[w] == 1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_cfg(input logic [7:0] mask, input int cls);
      int cnt, scnt;
      int nx [NW];
      bit bad_grp, bad_stash;
      string tag;
      cnt = $countones(mask);
      scnt = 0;
      for (int w = 0; w < NW; w++) begin
         nx[w] = mask[w] ? cls : m_cls[w];
         if (nx[w] == 1) scnt++;
      end
      bad_grp   = !(cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8) || cls > 4;
      bad_stash = !(scnt == 0 || scnt == 1 || scnt == 2 || scnt == 4);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mask = mask; cfg_cls = cls[2:0];
      @(negedge clk);
      cfg_we = 1'b0;
      tag = bad_grp ? "R3 group/class reject" : (bad_stash ? "R4 stash count reject" : "R2 accepted write");
      check(tag, int'(cfg_err), int'(bad_grp || bad_stash));
      if (!bad_grp && !bad_stash)
         for (int w = 0; w < NW; w++) m_cls[w] = nx[w];
   endtask

   task automatic set_mode(input bit v);
      @(negedge clk);
      mode_we = 1'b1; mode_stash_noalloc = v;
      @(negedge clk);
      mode_we = 1'b0;
      m_mode = v;
   endtask

   task automatic do_req(input int src, input bit hit, input int hw, input logic [7:0] lv);
      int e_al, e_up, e_na, e_vic, found, w;
      string tag;
      e_al = 0; e_up = 0; e_na = 0; e_vic = 0;
      if (hit) begin
         e_up = 1; e_vic = hw; tag = "R11 hit update";
      end else if (src == 2 && m_mode) begin
         e_na = 1; tag = "R12 stash no-allocate mode";
      end else begin
         found = -1;
         for (int i = NW - 1; i >= 0; i--) if (m_elig(src, i) && !lv[i]) found = i;
         if (found >= 0) begin
            e_al = 1; e_vic = found; tag = "R8 lowest invalid";
         end else begin
            found = -1;
            for (int i = NW - 1; i >= 0; i--) begin
               w = (m_ptr[src < 3 ? src : 0] + i) % NW;
               if (m_elig(src, w)) found = w;
            end
            if (found >= 0) begin
               e_al = 1; e_vic = found; tag = "R9 round robin";
               m_ptr[src] = (found + 1) % NW;
            end else begin
               e_na = 1; tag = "R10 no eligible way";
            end
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_src = src[1:0]; req_hit = hit;
      req_hit_way = hw[2:0]; req_line_valid = lv;
      @(negedge clk);
      req_valid = 1'b0;
      check("R13 dec_valid", int'(dec_valid), 1);
      check(tag, int'({dec_alloc, dec_update, dec_noalloc, dec_victim}),
            (e_al << 5) | (e_up << 4) | (e_na << 3) | e_vic);
      if (dec_alloc) begin
         check("R6 victim not SRAM", int'(m_cls[dec_victim] == 0), 0);
         if (src == 2) check("R5 stash victim stash-only", m_cls[dec_victim], 1);
         else begin
            check("R5 cpu victim not stash-only", int'(m_cls[dec_victim] == 1), 0);
            check("R7 cpu victim in own partition", int'(m_elig(src, dec_victim)), 1);
         end
      end
   endtask

   task automatic sweep_misses(input int src);
      for (int v = 0; v < 256; v++) do_req(src, 1'b0, 0, v[7:0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < NW; w++) m_cls[w] = 4;
      for (int s = 0; s < 3; s++) m_ptr[s] = 0;
      m_mode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset dec_valid", int'(dec_valid), 0);
      check("R1 reset outputs", int'({dec_alloc, dec_update, dec_noalloc, cfg_err}), 0);
      // R1: all shared -> stash has nothing; CPU0 takes way 0 when empty
      do_req(2, 1'b0, 0, 8'h00);
      do_req(0, 1'b0, 0, 8'h00);
      do_req(1, 1'b0, 0, 8'hFF);
      @(negedge clk);
      check("R13 dec_valid idle", int'(dec_valid), 0);

      // R3: group size sweep with shared class, then bad class codes
      for (int m = 0; m < 256; m++) do_cfg(m[7:0], 4);
      for (int c = 5; c < 8; c++) do_cfg(8'h01, c);
      // R4: stash grouping sweep
      for (int m = 0; m < 256; m++) begin
         do_cfg(8'hFF, 4);
         do_cfg(m[7:0], 1);
      end
      do_cfg(8'hFF, 4);
      do_cfg(8'h03, 1);
      do_cfg(8'h04, 1);

      // R2 partition A: stash 0-1, cpu0 2-3, cpu1 4-5, shared 6, sram 7
      do_cfg(8'hFF, 4);
      do_cfg(8'h03, 1);
      do_cfg(8'h0C, 2);
      do_cfg(8'h30, 3);
      do_cfg(8'h80, 0);
      for (int s = 0; s < 4; s++) sweep_misses(s);
      for (int s = 0; s < 3; s++)
         for (int h = 0; h < NW; h++) do_req(s, 1'b1, h, 8'hFF);

      // R12: stash no-allocate mode
      set_mode(1'b1);
      sweep_misses(2);
      for (int h = 0; h < NW; h++) do_req(2, 1'b1, h, 8'hFF);
      sweep_misses(0);
      set_mode(1'b0);
      for (int k = 0; k < 6; k++) do_req(2, 1'b0, 0, 8'hFF);

      // R10 partition B: cpu1 0-3, stash 4-7, nothing for cpu0
      do_cfg(8'h0F, 3);
      do_cfg(8'hF0, 1);
      for (int s = 0; s < 3; s++) sweep_misses(s);
      // R2: write then immediate request sees the new table
      do_cfg(8'h01, 2);
      do_req(0, 1'b0, 0, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule